// File: doc/BRIEF.md
# Block Load/Store Multiple Sequencer

This block carries out one multi-register memory instruction across several clock cycles. A single-cycle start pulse brings in the 32-bit instruction word, the current value of the base register and the condition flags. The sequencer checks the instruction class and its condition. It then walks the 16-bit register list and makes one word transfer to or from memory for each selected register. Registers go from the lowest number to the highest, at consecutive rising word addresses.

The addressing mode is set by two bits: increment or decrement, and before or after. The mode sets the lowest address of the window and the updated base value. For a store, the register value is read through a combinational register-file read port and sent as write data. For a load, the returned word is written into the register file in the same cycle as the handshake. When the instruction asks for base write-back, the block gives the new base value and the base register number alongside a one-cycle done pulse.

Top module: `blk_xfer_seq`

## Requirements
- R1: An instruction is a block transfer only when bits 27..25 equal 3'b100. Any other word is accepted but produces no memory request, and done_o pulses in the first cycle after the start edge.
- R2: The condition field in bits 31..28 is tested against flags_i, where bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. Codes 0..13 follow the usual meanings: EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE. Code 14 always executes and code 15 never executes. A failed condition gives done_o in the first cycle after start, with no request and no write-back.
- R3: Bit n of the list in bits 15..0 selects register n. Exactly one handshake occurs per set bit, in ascending register order.
- R4: Bit 24 (before=1) and bit 23 (up=1) select the mode. With n selected registers the lowest address is base for increment-after, base+4 for increment-before, base-4n+4 for decrement-after and base-4n for decrement-before. Each later transfer uses the previous address plus 4.
- R5: When bit 20 is 0 (store), mem_we_o is 1, rf_raddr_o names the register being transferred, mem_wdata_o carries rf_rdata_i, and rf_we_o stays 0.
- R6: When bit 20 is 1 (load), in the handshake cycle rf_we_o is 1, rf_waddr_o names the register, rf_wdata_o carries mem_rdata_i, and mem_we_o is 0.
- R7: A request stays asserted with stable address and direction until mem_ready_i is seen high. Each such cycle completes exactly one transfer.
- R8: If bit 21 is set and the list is not empty and the condition passes, wb_valid_o rises with done_o. In that case new_base_o equals base+4n when counting up and base-4n when counting down, and wb_reg_o equals bits 19..16.
- R9: An empty list completes in the first cycle after start, with no memory request and no write-back.
- R10: done_o is a one-cycle pulse in the cycle after the last handshake. busy_o is high from start until done, and start_i is ignored while busy.
- R11: While rst_ni is low, busy_o, done_o, mem_req_o, rf_we_o and wb_valid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept a new instruction (idle only) |
| instr_i | input | 32 | Instruction word |
| base_i | input | ADDR_W | Current base register value |
| flags_i | input | 4 | N, Z, C, V condition flags |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Base write-back required (with done_o) |
| wb_reg_o | output | IDX_W | Base register number |
| new_base_o | output | ADDR_W | Updated base value |
| mem_req_o | output | 1 | Memory request valid |
| mem_addr_o | output | ADDR_W | Word address |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_wdata_o | output | DATA_W | Store data |
| mem_rdata_i | input | DATA_W | Load data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Memory accepts or completes the transfer |
| rf_raddr_o | output | IDX_W | Register-file read index |
| rf_rdata_i | input | DATA_W | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | IDX_W | Register-file write index |
| rf_wdata_o | output | DATA_W | Register-file write data |

## Verification
The bench builds the block with its default values: 32-bit addresses and data and a 16-entry register list. With these values a full 16-register list, the top register and the upper base register numbers can all be reached. The vectors cover all four addressing modes, both directions of transfer, memory stalls of zero to two cycles, passing and failing conditions, an empty list and a word outside the instruction class. Each case is checked against addresses, register indices and data predicted by the bench. A start pulse given in the middle of a stalled transfer shows that a busy sequencer does not accept a new instruction.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_st_e;

  localparam int unsigned BIT_LOAD = 20;
  localparam int unsigned BIT_WB   = 21;
  localparam int unsigned BIT_UP   = 23;
  localparam int unsigned BIT_PRE  = 24;
  localparam logic [2:0]  CLASS_BLOCK = 3'b100;
endpackage

// File: rtl/blk_cond_eval.sv
module blk_cond_eval (
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       pass_o
);
  logic f_n, f_z, f_c, f_v;
  logic base_pass;
  assign {f_n, f_z, f_c, f_v} = flags_i;

  // even code tests, odd code inverts; 14 always, 15 never
  always_comb begin
    case (cond_i[3:1])
      3'd0:    base_pass = f_z;
      3'd1:    base_pass = f_c;
      3'd2:    base_pass = f_n;
      3'd3:    base_pass = f_v;
      3'd4:    base_pass = f_c & ~f_z;
      3'd5:    base_pass = (f_n == f_v);
      3'd6:    base_pass = ~f_z & (f_n == f_v);
      default: base_pass = 1'b1;
    endcase
    if (cond_i[3:1] == 3'd7) pass_o = ~cond_i[0];
    else                     pass_o = base_pass ^ cond_i[0];
  end
endmodule

// File: rtl/blk_list_scan.sv
module blk_list_scan #(
  parameter int unsigned NREG  = 16,
  parameter int unsigned IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [NREG-1:0]  onehot_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign onehot_o = mask_i & (~mask_i + NREG'(1));
  assign any_o    = |mask_i;
endmodule

// File: rtl/blk_addr_plan.sv
module blk_addr_plan #(
  parameter int unsigned NREG       = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned CNT_W      = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]   list_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              pre_i,
  input  logic              up_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] low_o,
  output logic [ADDR_W-1:0] new_base_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NREG; i++) cnt_o = cnt_o + CNT_W'(list_i[i]);
  end

  assign span = ADDR_W'(cnt_o) * STEP;

  always_comb begin
    case ({pre_i, up_i})
      2'b01:   low_o = base_i;
      2'b11:   low_o = base_i + STEP;
      2'b00:   low_o = base_i - span + STEP;
      default: low_o = base_i - span;
    endcase
  end

  assign new_base_o = up_i ? (base_i + span) : (base_i - span);
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int unsigned NREG       = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned IDX_W      = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       instr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [3:0]        flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_reg_o,
  output logic [ADDR_W-1:0] new_base_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [IDX_W-1:0]  rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o
);
  localparam int unsigned CNT_W = $clog2(NREG + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seq_st_e           st_q;
  logic [NREG-1:0]   mask_q;
  logic [ADDR_W-1:0] addr_q, nbase_q;
  logic              load_q, wb_q;
  logic [IDX_W-1:0]  breg_q;

  logic              cond_ok, is_block, accept, go, hs;
  logic [NREG-1:0]   list_w, onehot, mask_nx;
  logic [IDX_W-1:0]  cur_idx;
  logic              list_any, mask_any;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] low_addr, nbase_w;
  logic              unused_bits;

  assign unused_bits = ^{instr_i[22], instr_i[15:NREG], cnt};
  assign list_w      = instr_i[NREG-1:0];
  assign is_block    = (instr_i[27:25] == CLASS_BLOCK);

  blk_cond_eval u_cond (
    .cond_i  (instr_i[31:28]),
    .flags_i (flags_i),
    .pass_o  (cond_ok)
  );

  blk_addr_plan #(.NREG(NREG), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_plan (
    .list_i     (list_w),
    .base_i     (base_i),
    .pre_i      (instr_i[BIT_PRE]),
    .up_i       (instr_i[BIT_UP]),
    .cnt_o      (cnt),
    .low_o      (low_addr),
    .new_base_o (nbase_w)
  );

  blk_list_scan #(.NREG(NREG), .IDX_W(IDX_W)) u_scan (
    .mask_i   (mask_q),
    .idx_o    (cur_idx),
    .onehot_o (onehot),
    .any_o    (mask_any)
  );

  assign list_any = |list_w;
  assign accept   = start_i && (st_q == ST_IDLE);
  assign go       = is_block && cond_ok && list_any;
  assign hs       = (st_q == ST_XFER) && mem_ready_i;
  assign mask_nx  = mask_q & ~onehot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      nbase_q <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      breg_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= go ? ST_XFER : ST_FIN;
          mask_q  <= go ? list_w : '0;
          addr_q  <= low_addr;
          nbase_q <= nbase_w;
          load_q  <= instr_i[BIT_LOAD];
          wb_q    <= go && instr_i[BIT_WB];
          breg_q  <= IDX_W'(instr_i[19:16]);
        end
        ST_XFER: if (hs) begin
          mask_q <= mask_nx;
          addr_q <= addr_q + STEP;
          if (mask_nx == '0) st_q <= ST_FIN;
        end
        default: begin
          st_q <= ST_IDLE;
          wb_q <= 1'b0;
        end
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign wb_valid_o  = done_o && wb_q;
  assign wb_reg_o    = breg_q;
  assign new_base_o  = nbase_q;

  assign mem_req_o   = (st_q == ST_XFER) && mask_any;
  assign mem_addr_o  = addr_q;
  assign mem_we_o    = mem_req_o && !load_q;
  assign rf_raddr_o  = cur_idx;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_we_o     = hs && load_q;
  assign rf_waddr_o  = cur_idx;
  assign rf_wdata_o  = mem_rdata_i;

  // R4: transfers sit on word boundaries and step upward by one word
  assert_addr_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o % STEP) == '0);
  assert_addr_ascend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + STEP));
  // R7: stalled request holds address and direction
  assert_hold_on_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R6: register write only on a completed load beat
  assert_rf_write_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (mem_req_o && mem_ready_i && !mem_we_o));
  // R10: done is a single-cycle pulse with no request alongside
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_no_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
  // R8: write-back only alongside done
  assert_wb_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);
  // R10: request and done only while busy
  assert_req_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || done_o) |-> busy_o);
endmodule

// File: tb/tb_blk_xfer_seq.sv
module tb_blk_xfer_seq;
  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] base;
    logic [3:0]  flags;
    logic [3:0]  stall;
    logic [4:0]  exp_n;
    logic [31:0] exp_first;
    logic        exp_wb;
    logic [31:0] exp_nbase;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'hE92D041F, 32'h1000, 4'h0, 4'd1, 5'd6,  32'h0FE8, 1'b1, 32'h0FE8}, // DB store wb
    '{32'h08855555, 32'h0200, 4'h4, 4'd0, 5'd8,  32'h0200, 1'b0, 32'h0220}, // EQ pass IA
    '{32'h08855555, 32'h0200, 4'h0, 4'd0, 5'd0,  32'h0000, 1'b0, 32'h0000}, // EQ fail
    '{32'hE9B18003, 32'h0100, 4'h0, 4'd2, 5'd3,  32'h0104, 1'b1, 32'h010C}, // IB load wb
    '{32'hE81200F0, 32'h0300, 4'h0, 4'd1, 5'd4,  32'h02F4, 1'b0, 32'h02F0}, // DA load
    '{32'hE8A30000, 32'h0080, 4'h0, 4'd0, 5'd0,  32'h0000, 1'b0, 32'h0000}, // empty list
    '{32'hE8B4FFFF, 32'h0040, 4'h0, 4'd0, 5'd16, 32'h0040, 1'b1, 32'h0080}, // full list
    '{32'hE1A0F00E, 32'h0000, 4'h0, 4'd0, 5'd0,  32'h0000, 1'b0, 32'h0000}, // not block
    '{32'hC9068001, 32'h0500, 4'h9, 4'd0, 5'd2,  32'h04F8, 1'b0, 32'h04F8}  // GT pass DB
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] base_i = '0;
  logic [3:0]  flags_i = '0;
  logic        busy_o, done_o, wb_valid_o, mem_req_o, mem_we_o, rf_we_o;
  logic [3:0]  wb_reg_o, rf_raddr_o, rf_waddr_o;
  logic [31:0] new_base_o, mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o;
  logic        mem_ready_i = 1'b0;

  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  assign mem_rdata_i = mem_addr_o ^ 32'h5A5A_0000;
  assign rf_rdata_i  = {16'hC0DE, 12'h000, rf_raddr_o};

  blk_xfer_seq dut (
    .clk_i, .rst_ni, .start_i, .instr_i, .base_i, .flags_i,
    .busy_o, .done_o, .wb_valid_o, .wb_reg_o, .new_base_o,
    .mem_req_o, .mem_addr_o, .mem_we_o, .mem_wdata_o, .mem_rdata_i, .mem_ready_i,
    .rf_raddr_o, .rf_rdata_i, .rf_we_o, .rf_waddr_o, .rf_wdata_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    logic [15:0] rem;
    logic [31:0] eaddr;
    int hs = 0, reqs = 0, last_hs = -1, done_cyc = -1, nreg;
    bit seen_done = 0;
    @(negedge clk_i);
    start_i = 1'b1; instr_i = v.instr; base_i = v.base; flags_i = v.flags;
    @(negedge clk_i);
    start_i = 1'b0;
    rem = v.instr[15:0];
    eaddr = v.exp_first;
    for (int cyc = 0; cyc < 300 && !seen_done; cyc++) begin
      if (cyc > 0) @(negedge clk_i);
      if (poke && cyc == 0) begin start_i = 1'b1; instr_i = 32'hE8B0FFFF; end
      else start_i = 1'b0;
      mem_ready_i = ((cyc % (int'(v.stall) + 1)) == int'(v.stall));
      #1;
      if (mem_req_o) reqs++;
      if (mem_req_o && mem_ready_i) begin
        nreg = 0;
        for (int b = 15; b >= 0; b--) if (rem[b]) nreg = b;
        chk(rem != 0, "R3", "extra transfer", 32'(hs), 32'(v.exp_n));
        chk(mem_addr_o == eaddr, "R4", "address", mem_addr_o, eaddr);
        if (!v.instr[20]) begin
          chk(mem_we_o && !rf_we_o, "R5", "store direction", {mem_we_o, rf_we_o}, 32'h2);
          chk(rf_raddr_o == 4'(nreg), "R3", "read index", 32'(rf_raddr_o), 32'(nreg));
          chk(mem_wdata_o == {16'hC0DE, 12'h000, 4'(nreg)}, "R5", "store data",
              mem_wdata_o, {16'hC0DE, 12'h000, 4'(nreg)});
        end else begin
          chk(!mem_we_o && rf_we_o, "R6", "load direction", {mem_we_o, rf_we_o}, 32'h1);
          chk(rf_waddr_o == 4'(nreg), "R3", "write index", 32'(rf_waddr_o), 32'(nreg));
          chk(rf_wdata_o == (eaddr ^ 32'h5A5A_0000), "R6", "load data",
              rf_wdata_o, eaddr ^ 32'h5A5A_0000);
        end
        rem[nreg] = 1'b0;
        eaddr += 4;
        hs++;
        last_hs = cyc;
      end
      if (done_o) begin
        seen_done = 1;
        done_cyc = cyc;
        chk(wb_valid_o == v.exp_wb, "R8", "write-back flag", 32'(wb_valid_o), 32'(v.exp_wb));
        if (v.exp_wb) begin
          chk(new_base_o == v.exp_nbase, "R8", "new base", new_base_o, v.exp_nbase);
          chk(wb_reg_o == v.instr[19:16], "R8", "base reg", 32'(wb_reg_o), 32'(v.instr[19:16]));
        end
      end
    end
    mem_ready_i = 1'b0;
    chk(seen_done, "R10", "done seen", 32'(seen_done), 32'h1);
    chk(hs == int'(v.exp_n), "R3", "transfer count", 32'(hs), 32'(v.exp_n));
    chk(reqs == int'(v.exp_n) * (int'(v.stall) + 1), "R7", "request cycles",
        32'(reqs), 32'(int'(v.exp_n) * (int'(v.stall) + 1)));
    if (v.exp_n == 0)
      chk(done_cyc == 0, "R9", "early done cycle (R1/R2)", 32'(done_cyc), 32'h0);
    else
      chk(done_cyc == last_hs + 1, "R10", "done cycle", 32'(done_cyc), 32'(last_hs + 1));
    for (int k = 0; k < 2; k++) begin
      @(negedge clk_i); #1;
      chk(!busy_o && !mem_req_o && !done_o, "R10", "idle after done",
          {busy_o, mem_req_o, done_o}, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(!busy_o && !done_o && !mem_req_o && !rf_we_o && !wb_valid_o, "R11", "reset outputs",
        {busy_o, done_o, mem_req_o, rf_we_o, wb_valid_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!busy_o && !mem_req_o, "R11", "idle after reset", {busy_o, mem_req_o}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // start pulse during a stalled load must be ignored (R10)
    run_vec(VECS[3], 1'b1);
    // another condition code: LT with N!=V fails when N==V
    run_vec('{32'hB9068001, 32'h0500, 4'h9, 4'd0, 5'd0, 32'h0, 1'b0, 32'h0}, 1'b0); // R2
    // never-execute code 15
    run_vec('{32'hF8B4FFFF, 32'h0040, 4'h0, 4'd0, 5'd0, 32'h0, 1'b0, 32'h0}, 1'b0); // R2

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule